// File: doc/BRIEF.md
# Double-Buffered Byte-Lane Converter Code Register

This block is the digital front end of a 16-bit converter. A host writes a parallel data word into an input register that is split into byte lanes. Each lane has its own active-low select, and one shared active-low write strobe qualifies all the selects. A separate active-low load strobe copies the input register into the output code register. The output code register holds the code that drives the converter. A host with a 16-bit bus writes both lanes at once. A host with an 8-bit bus ties each upper data bit to its matching lower bit and writes the two lanes in separate accesses.

The host controls are level-sensitive, and the block emulates that behaviour inside one system clock domain. All host inputs, data included, pass together through a synchronizer of `SYNC_STAGES` flops. The two register stages then act as clock-enabled stages. Each stage forwards its next value, so when write, every select and load are all low, a bus word reaches the code output at the same clock edge that captures it in the input register.

The clear input sets every register to zero at once, without waiting for a clock edge, and its release is synchronized. The power-on reset does the same. A one-cycle update pulse marks each clock edge at which the output code changes.

Top module: `dac_dbuf`

## Requirements
- R1: While write is low and only the high-lane select (sel_n bit 1) is low, data bits 15..8 go into the upper half of the input register and the lower half keeps its value.
- R2: While write is low and only the low-lane select (sel_n bit 0) is low, data bits 7..0 go into the lower half of the input register and the upper half keeps its value.
- R3: While write and both selects are low, both halves of the input register load from the full 16-bit bus in the same cycle.
- R4: While write is high, or while both selects are high, neither half of the input register changes.
- R5: While load is low, the output code follows the input register. While load is high, the output code holds its value.
- R6: While write, both selects and load are all low, the bus word reaches the code output at the same clock edge that captures it in the input register.
- R7: A low on clear sets the input register and the output code to zero at once, before the next clock edge and whatever the other controls are doing. After clear is released, a load with no write presents zero.
- R8: While the power-on reset is low, and after it is released, every register reads zero and the update pulse is low.
- R9: The update pulse is high for exactly one cycle after each clock edge at which the output code changes. It stays low when a write and load leave the code unchanged.
- R10: A host with an 8-bit bus drives the same byte on both lanes and writes the upper lane and then the lower lane in separate accesses. The loaded code is the upper byte followed by the lower byte.
- R11: A host input pattern driven between clock edges reaches the code output at rising edge SYNC_STAGES+1 (the third edge with the default of 2) and not at any earlier edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| clr_n | input | 1 | Clear, active low: asserts at once, release is synchronized |
| wr_n | input | 1 | Shared write strobe, active low |
| sel_n | input | LANES | Byte-lane selects, active low; bit i selects data bits [8i+7:8i] |
| ld_n | input | 1 | Load strobe for the output code register, active low |
| din | input | LANE_W*LANES | Parallel data bus |
| code | output | LANE_W*LANES | Held converter code |
| upd | output | 1 | One-cycle pulse after each edge at which code changed |

## Verification
On every clock cycle the assertions check several properties. An unselected or unwritten lane must hold its value, and a full-width write must capture the synchronized bus. The code must hold while load is inactive and must follow the input register while load is active. The update pulse must agree exactly with a change of code, and clear or reset must force every register to zero. Other behaviours show up only in the bench's scenarios: the three-edge latency, same-edge flow-through, the 8-bit host sequence, and the fact that clear wipes the input register, which becomes visible only through a later load. The same holds for the absence of a pulse when an identical value is written again.

// File: rtl/dacbuf_pkg.sv
package dacbuf_pkg;

   localparam int DEF_LANE_W = 8;
   localparam int DEF_LANES  = 2;
   localparam int DEF_SYNC   = 2;

   // host strobes after synchronization, active high
   typedef struct packed {
      logic wr;
      logic ld;
   } strobe_t;

endpackage

// File: rtl/dacbuf_sync.sv
module dacbuf_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2,
   parameter logic [W-1:0] INIT = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("dacbuf_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= INIT;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/dacbuf_rstgen.sv
module dacbuf_rstgen #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   output logic rst_o_n
);

   if (STAGES < 2) begin : g_bad_stages
      $error("dacbuf_rstgen: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) chain <= '0;
      else         chain <= {chain[STAGES-2:0], 1'b1};
   end

   assign rst_o_n = chain[STAGES-1];

endmodule

// File: rtl/dacbuf_lane.sv
module dacbuf_lane #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] d,
   output logic [W-1:0] q,
   output logic [W-1:0] q_nxt
);

   if (W < 1) begin : g_bad_width
      $error("dacbuf_lane: W must be positive");
   end

   // forwarded next value emulates a transparent latch
   assign q_nxt = we ? d : q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= q_nxt;
   end

   // R4: a lane that is not written keeps its contents
   a_r4_lane_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(q));

endmodule

// File: rtl/dacbuf_out.sv
module dacbuf_out #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ld,
   input  logic [W-1:0] d,
   output logic [W-1:0] code,
   output logic         upd
);

   logic [W-1:0] nxt;

   assign nxt = ld ? d : code;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code <= '0;
         upd  <= 1'b0;
      end else begin
         code <= nxt;
         upd  <= (nxt != code);
      end
   end

   // R5: hold while load inactive
   a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !ld |=> $stable(code));

   // R5: follow the input register while load active
   a_r5_follow: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> code == $past(d));

   // R9: a pulse only marks a real change
   a_r9_pulse_means_change: assert property (@(posedge clk) disable iff (!rst_n)
      upd |-> code != $past(code));

   // R9: every change is marked
   a_r9_change_pulsed: assert property (@(posedge clk) disable iff (!rst_n)
      code != $past(code) |-> upd);

endmodule

// File: rtl/dac_dbuf.sv
module dac_dbuf
   import dacbuf_pkg::*;
#(
   parameter int LANE_W      = DEF_LANE_W,
   parameter int LANES       = DEF_LANES,
   parameter int SYNC_STAGES = DEF_SYNC,
   localparam int WIDTH      = LANE_W * LANES
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_n,
   input  logic             wr_n,
   input  logic [LANES-1:0] sel_n,
   input  logic             ld_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] code,
   output logic             upd
);

   localparam int SW = WIDTH + LANES + 2;
   localparam logic [SW-1:0] SYNC_INIT = {{(LANES+2){1'b1}}, {WIDTH{1'b0}}};

   if (LANE_W < 1 || LANES < 1) begin : g_bad_geometry
      $error("dac_dbuf: LANE_W and LANES must be positive");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("dac_dbuf: SYNC_STAGES must be at least 2");
   end

   logic [SW-1:0]    raw, synced;
   strobe_t          stb;
   logic [LANES-1:0] sel;
   logic [WIDTH-1:0] dsync;
   logic [WIDTH-1:0] in_q, in_nxt;
   logic             arst_n, rst_i_n;

   // data and strobes cross together so they stay aligned
   assign raw = {ld_n, wr_n, sel_n, din};

   dacbuf_sync #(.W(SW), .STAGES(SYNC_STAGES), .INIT(SYNC_INIT)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw),
      .q     (synced)
   );

   assign stb.ld = ~synced[SW-1];
   assign stb.wr = ~synced[SW-2];
   assign sel    = ~synced[WIDTH +: LANES];
   assign dsync  = synced[WIDTH-1:0];

   assign arst_n = rst_n & clr_n;

   dacbuf_rstgen #(.STAGES(SYNC_STAGES)) u_rst (
      .clk     (clk),
      .arst_n  (arst_n),
      .rst_o_n (rst_i_n)
   );

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      dacbuf_lane #(.W(LANE_W)) u_lane (
         .clk   (clk),
         .rst_n (rst_i_n),
         .we    (stb.wr & sel[g]),
         .d     (dsync[g*LANE_W +: LANE_W]),
         .q     (in_q[g*LANE_W +: LANE_W]),
         .q_nxt (in_nxt[g*LANE_W +: LANE_W])
      );
   end

   dacbuf_out #(.W(WIDTH)) u_out (
      .clk   (clk),
      .rst_n (rst_i_n),
      .ld    (stb.ld),
      .d     (in_nxt),
      .code  (code),
      .upd   (upd)
   );

   // R7, R8: clear or reset forces all stages to zero
   a_r7_clear_zero: assert property (@(posedge clk)
      (!clr_n || !rst_n) |-> (code == '0 && in_q == '0));

   // R4: no write strobe or no select leaves the input register alone
   a_r4_no_write: assert property (@(posedge clk) disable iff (!rst_i_n)
      (!stb.wr || sel == '0) |=> $stable(in_q));

   // R3: full-width write captures the whole bus
   a_r3_full_write: assert property (@(posedge clk) disable iff (!rst_i_n)
      (stb.wr && (&sel)) |=> in_q == $past(dsync));

endmodule

// File: tb/dac_dbuf_test.sv
module dac_dbuf_test;

   localparam int SYNC = 2;
   localparam int NV   = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        clr_n = 1'b1;
   logic        wr_n = 1'b1;
   logic [1:0]  sel_n = 2'b11;
   logic        ld_n = 1'b1;
   logic [15:0] din = '0;
   logic [15:0] code;
   logic        upd;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   dac_dbuf #(.LANE_W(8), .LANES(2), .SYNC_STAGES(SYNC)) uut (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_n (clr_n),
      .wr_n  (wr_n),
      .sel_n (sel_n),
      .ld_n  (ld_n),
      .din   (din),
      .code  (code),
      .upd   (upd)
   );

   // {wr_n, sel_n[1], sel_n[0], ld_n, din, expected code, requirement}
   localparam logic [43:0] VEC [NV] = '{
      {1'b0, 1'b0, 1'b1, 1'b1, 16'hA5C3, 16'h0000, 8'd1},  // R1 upper write, R5 hold
      {1'b1, 1'b1, 1'b1, 1'b0, 16'hFFFF, 16'hA500, 8'd1},  // R1 lower untouched
      {1'b0, 1'b1, 1'b0, 1'b0, 16'h1234, 16'hA534, 8'd2},  // R2 lower write
      {1'b0, 1'b1, 1'b1, 1'b0, 16'hFFFF, 16'hA534, 8'd4},  // R4 no select
      {1'b1, 1'b0, 1'b0, 1'b0, 16'h0F0F, 16'hA534, 8'd4},  // R4 write high
      {1'b0, 1'b0, 1'b0, 1'b1, 16'h5AA5, 16'hA534, 8'd5},  // R5 hold during R3 write
      {1'b1, 1'b1, 1'b1, 1'b0, 16'h0000, 16'h5AA5, 8'd3},  // R3 both lanes loaded
      {1'b0, 1'b0, 1'b0, 1'b0, 16'h8001, 16'h8001, 8'd6},  // R6 flow-through
      {1'b0, 1'b0, 1'b0, 1'b0, 16'h7FFE, 16'h7FFE, 8'd6},  // R6 flow-through
      {1'b1, 1'b1, 1'b1, 1'b1, 16'h0000, 16'h7FFE, 8'd5}   // R5 hold
   };

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic settle();
      repeat (SYNC + 3) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic count_pulses(input int ncyc, output int n);
      n = 0;
      for (int k = 0; k < ncyc; k++) begin
         @(negedge clk);
         if (upd) n++;
      end
   endtask

   initial begin
      int n;
      // R8: reset state
      #5;
      check("R8 code in reset", code, 16'h0000);
      check("R8 upd in reset", {15'd0, upd}, 16'h0000);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      settle();
      check("R8 code after reset", code, 16'h0000);
      check("R8 upd after reset", {15'd0, upd}, 16'h0000);

      for (int i = 0; i < NV; i++) begin
         {wr_n, sel_n[1], sel_n[0], ld_n} = VEC[i][43:40];
         din = VEC[i][39:24];
         settle();
         check($sformatf("R%0d vector %0d", VEC[i][7:0], i), code, VEC[i][23:8]);
      end

      // R9: one pulse on a change, none on an identical rewrite
      wr_n = 1'b1; sel_n = 2'b11; ld_n = 1'b0;
      settle();
      wr_n = 1'b0; sel_n = 2'b00; din = 16'h1111;
      count_pulses(10, n);
      check("R9 one pulse on change", n[15:0], 16'd1);
      check("R9 code after change", code, 16'h1111);
      wr_n = 1'b1;
      settle();
      wr_n = 1'b0;
      count_pulses(10, n);
      check("R9 no pulse on same value", n[15:0], 16'd0);

      // R11: latency of SYNC+1 edges, flow-through active
      din = 16'h2222;
      repeat (SYNC) @(posedge clk);
      @(negedge clk);
      check("R11 not yet at edge SYNC", code, 16'h1111);
      @(posedge clk);
      @(negedge clk);
      check("R11 present at edge SYNC+1", code, 16'h2222);

      // R10: 8-bit host, byte replicated on both lanes
      wr_n = 1'b1; sel_n = 2'b11; ld_n = 1'b1;
      settle();
      din = {8'h3C, 8'h3C}; sel_n = 2'b01; wr_n = 1'b0;
      settle();
      wr_n = 1'b1;
      settle();
      din = {8'hC3, 8'hC3}; sel_n = 2'b10; wr_n = 1'b0;
      settle();
      wr_n = 1'b1; sel_n = 2'b11;
      settle();
      check("R10 code held before load", code, 16'h2222);
      ld_n = 1'b0;
      settle();
      check("R10 byte sequence loaded", code, 16'h3CC3);

      // R7: clear is immediate and overrides all strobes
      #5;
      clr_n = 1'b0;
      #1;
      check("R7 immediate clear", code, 16'h0000);
      wr_n = 1'b0; sel_n = 2'b00; ld_n = 1'b0; din = 16'hFFFF;
      settle();
      check("R7 clear overrides strobes", code, 16'h0000);
      wr_n = 1'b1; sel_n = 2'b11; ld_n = 1'b1;
      settle();
      clr_n = 1'b1;
      settle();
      ld_n = 1'b0;
      settle();
      check("R7 input register cleared", code, 16'h0000);

      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule